// File: doc/BRIEF.md
# Fixed-Latency Sample Delay Line

This block holds back a stream of data words by a fixed number of accepted samples. Each word presented with its valid input high is stored in a circular buffer that maps onto on-chip block RAM. Once enough words have been stored to cover the delay, every later accepted word releases the word that was accepted `LATENCY` samples before it. The delay is counted in accepted samples, not in clock cycles, so gaps in the input stream do not change which word comes out.

The buffer read is registered to suit block RAM. For that reason each output word appears one clock after the internal read request, and output valid is pipelined to match. The block uses one clock and a synchronous active-low reset. It has no back-pressure and no run-time latency control.

Top module: `sample_delay_line`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `out_vld` is 0; the buffer contents are not cleared.
- R2: `out_vld` stays 0 until `LATENCY` samples have been accepted since reset. The first `out_vld` pulse follows the acceptance of the sample with zero-based index `LATENCY`, which is the (`LATENCY`+1)-th sample.
- R3: Each time `out_vld` is 1, `out_data` equals the word accepted exactly `LATENCY` accepted samples before the sample that triggered it.
- R4: `out_vld` is 1 in the cycle after clock edge E+1 exactly when `in_vld` was 1 at edge E and the buffer was primed; no output is produced on a cycle without accepted input.
- R5: Idle cycles between accepted samples do not shift the delay relationship, because the pointers move only on accepted samples.
- R6: The buffer is circular with `DEPTH` entries and all pointer arithmetic wraps modulo `DEPTH`; the delay stays correct after more than `DEPTH` samples.
- R7: A reset applied during operation discards the primed state, so another `LATENCY` accepted samples must pass before `out_vld` returns.
- R8: After `in_vld` falls, `out_vld` can be high for at most one further cycle and then stays low until input resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_W | Input word |
| in_vld | input | 1 | Input word is accepted on this edge |
| out_data | output | DATA_W | Delayed word, meaningful only with `out_vld` |
| out_vld | output | 1 | Delayed word valid |

## Verification
A word accepted at clock edge E schedules a read at E and appears on `out_data`/`out_vld` after edge E+1. It is therefore due two edges after it is driven. The bench drives at the falling edge and holds its expectation for one full step before comparing. Each step compares `out_vld` with the expectation computed for the previous step's stimulus, and compares `out_data` as well when that expectation says valid. The expected word comes from a bench history of accepted samples indexed by a count that resets with the block. Applying reset also clears the held expectation, because `out_vld` is cleared on the reset edge.

// File: rtl/dl_pkg.sv
// Package: shared defaults for the sample delay line.
// Assumes: consumers take these as parameter defaults only.
package dl_pkg;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_DEPTH   = 4096;
    localparam int DEF_LATENCY = 64;
endpackage

// File: rtl/dl_fill_tracker.sv
// Module: dl_fill_tracker
// Counts accepted samples after reset, saturating at LATENCY, and raises
// a sticky primed flag once LATENCY samples sit in the buffer.
// Assumes: LATENCY >= 1; acc is high for exactly the accepted samples.
module dl_fill_tracker #(
    parameter int LATENCY = dl_pkg::DEF_LATENCY,
    localparam int CW     = $clog2(LATENCY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    output logic primed
);
    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

    logic [CW-1:0] fill_cnt;

    // Purpose: saturating fill count and the primed flag it drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            primed   <= 1'b0;
        end else if (acc && !primed) begin
            fill_cnt <= fill_cnt + 1'b1;
            if (fill_cnt == LAST) begin
                primed <= 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(LATENCY)); // R2
    AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> primed); // R2
    AST_PRIME_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed) |-> $past(acc)); // R2
endmodule

// File: rtl/dl_ptr_gen.sv
// Module: dl_ptr_gen
// Keeps the circular write pointer and issues a read request at
// write pointer minus LATENCY for each accepted sample once primed.
// Assumes: DEPTH is a power of two so pointer wrap is free.
module dl_ptr_gen #(
    parameter int DEPTH   = dl_pkg::DEF_DEPTH,
    parameter int LATENCY = dl_pkg::DEF_LATENCY,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          primed,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          rd_req
);
    localparam logic [AW-1:0] LAT_A = AW'(LATENCY);

    // Purpose: advance the write pointer on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (acc) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Purpose: register the read address and its request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            rd_req <= 1'b0;
        end else begin
            rd_req <= acc && primed;
            if (acc && primed) begin
                rd_ptr <= wr_ptr - LAT_A;
            end
        end
    end

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (wr_ptr == $past(wr_ptr) + 1'b1)); // R6
    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(wr_ptr)); // R5
    AST_RD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (AW'(wr_ptr - rd_ptr) == AW'(LATENCY + 1))); // R3
    AST_NO_REQ_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !primed) |=> !rd_req); // R2
endmodule

// File: rtl/dl_ram.sv
// Module: dl_ram
// Simple dual-port storage with a registered read, shaped for block RAM
// inference, plus the valid stage that tracks the read register.
// Assumes: contents are never reset; read data is meaningful only with vld_q.
module dl_ram #(
    parameter int DATA_W = dl_pkg::DEF_DATA_W,
    parameter int DEPTH  = dl_pkg::DEF_DEPTH,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata_q,
    output logic              vld_q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: write port, no reset on the array.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: registered read port.
    always_ff @(posedge clk) begin
        rdata_q <= mem[raddr];
    end

    // Purpose: valid stage aligned with the read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= re;
        end
    end

    AST_VLD_FOLLOWS_RE: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> vld_q); // R4
endmodule

// File: rtl/sample_delay_line.sv
// Module: sample_delay_line (top)
// Delays accepted words by LATENCY accepted samples through a circular
// block RAM buffer; output valid runs one stage behind the read request.
// Assumes: 1 <= LATENCY < DEPTH, DEPTH a power of two, one clock domain.
module sample_delay_line #(
    parameter int DATA_W  = dl_pkg::DEF_DATA_W,
    parameter int DEPTH   = dl_pkg::DEF_DEPTH,
    parameter int LATENCY = dl_pkg::DEF_LATENCY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    output logic [DATA_W-1:0] out_data,
    output logic              out_vld
);
    localparam int AW = $clog2(DEPTH);

    logic          primed;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          rd_req;

    initial begin
        assert (LATENCY >= 1 && LATENCY < DEPTH && (1 << AW) == DEPTH)
            else $error("sample_delay_line: bad LATENCY or DEPTH");
    end

    dl_fill_tracker #(.LATENCY(LATENCY)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (in_vld),
        .primed (primed)
    );

    dl_ptr_gen #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (in_vld),
        .primed (primed),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .rd_req (rd_req)
    );

    dl_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (in_vld),
        .waddr   (wr_ptr),
        .wdata   (in_data),
        .re      (rd_req),
        .raddr   (rd_ptr),
        .rdata_q (out_data),
        .vld_q   (out_vld)
    );

    AST_OUT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 2)); // R4
    AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !out_vld); // R8
    AST_NO_OUT_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> !rd_req); // R7
endmodule

// File: tb/sample_delay_line_tb_top.sv
// Bench: random and directed stimulus against a history-based model.
module sample_delay_line_tb_top;
    localparam int DW  = 32;
    localparam int DEP = 4096;
    localparam int LAT = 64;
    localparam int HIST = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_vld = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_vld;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] hist [HIST];
    int            acc_cnt = 0;
    logic          pend_v = 1'b0;
    logic [DW-1:0] pend_d = '0;
    string         tag = "R1";

    always #2.5 clk = ~clk;

    sample_delay_line #(.DATA_W(DW), .DEPTH(DEP), .LATENCY(LAT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_vld   (in_vld),
        .out_data (out_data),
        .out_vld  (out_vld)
    );

    // Expected output word for the sample with index k.
    function automatic logic [DW-1:0] exp_word(int k);
        return hist[(k - LAT) % HIST];
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // One clock: drive at falling edge, check previous expectation after next edge.
    task automatic step(input logic v, input logic [DW-1:0] d);
        logic          cur_v;
        logic [DW-1:0] cur_d;
        in_vld  = v;
        in_data = d;
        cur_v = 1'b0;
        cur_d = '0;
        if (rst_n && v) begin
            if (acc_cnt >= LAT) begin
                cur_v = 1'b1;
                cur_d = exp_word(acc_cnt);
            end
            hist[acc_cnt % HIST] = d;
            acc_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_vld !== pend_v) begin
            errors++;
            $display("FAIL %s: out_vld=%b expected %b", tag, out_vld, pend_v);
        end else if (pend_v && out_data !== pend_d) begin
            errors++;
            $display("FAIL %s: out_data=%h expected %h", tag, out_data, pend_d);
        end
        pend_v = cur_v;
        pend_d = cur_d;
    endtask

    task automatic do_reset(input int cycles);
        rst_n   = 1'b0;
        pend_v  = 1'b0;
        acc_cnt = 0;
        for (int i = 0; i < cycles; i++) step(1'b1, $urandom);
        rst_n = 1'b1;
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset holds output low, also on the first cycle after release
        tag = "R1";
        do_reset(4);
        step(1'b0, '0);
        step(1'b0, '0);
        // R2: priming; no output for the first LAT samples, first one after index LAT
        tag = "R2";
        for (int i = 0; i < LAT + 3; i++) step(1'b1, $urandom);
        // R8: drain after input valid drops
        tag = "R8";
        for (int i = 0; i < 5; i++) step(1'b0, $urandom);
        // R4 R5: sparse random input valid, delay in samples
        tag = "R4 R5";
        for (int i = 0; i < 800; i++) step(($urandom % 10) < 3, $urandom);
        // R3: dense random traffic with directed extremes
        tag = "R3";
        for (int i = 0; i < 200; i++) step(($urandom % 10) < 8, $urandom);
        step(1'b1, 32'h0000_0000);
        step(1'b1, 32'hFFFF_FFFF);
        step(1'b1, 32'h8000_0001);
        // R6: wrap the circular buffer more than once
        tag = "R6";
        for (int i = 0; i < DEP + 600; i++) step(1'b1, $urandom);
        // R7: mid-operation reset, priming must restart
        tag = "R7";
        do_reset(2);
        for (int i = 0; i < LAT + 10; i++) step(($urandom % 4) != 0 || i > LAT, $urandom);
        for (int i = 0; i < 3; i++) step(1'b0, '0);
        summary();
        $finish;
    end
endmodule